// File: doc/BRIEF.md
# Unrolled Non-Restoring Integer Divider

This block divides one unsigned 32-bit integer by another in pure combinational logic. It returns a 32-bit quotient and a 32-bit remainder. Inside it is a chain of add/subtract rows, one row for each quotient bit. Each row looks at the sign of the running partial remainder and then either adds or subtracts the divisor. No row ever restores the partial remainder. The first thirty-one rows are copies of one generated row. The last row is a separate design, because it also adds the divisor back once when the remainder it ends with is negative.

In the surrounding datapath the quotient is loaded into the low result register and the remainder into the high result register. A zero divisor does not raise an exception. Instead it forces a fixed answer: a quotient of all zeros and a remainder of all ones. A flag output reports that this case has occurred.

Top module: `nr_array_divider`

## Requirements
- R1: For a nonzero divisor, `quot_o` equals the unsigned floor of `numer_i` divided by `denom_i`.
- R2: For a nonzero divisor, `rem_o` equals `numer_i` modulo `denom_i` (unsigned), so `quot_o * denom_i + rem_o == numer_i`.
- R3: For a nonzero divisor, `rem_o` is strictly less than `denom_i`.
- R4: When `denom_i` is zero, `quot_o` is 32'h0000_0000 and `rem_o` is 32'hFFFF_FFFF, whatever the value of `numer_i`.
- R5: `zero_div_o` is 1 exactly when `denom_i` is zero, and 0 otherwise.
- R6: When `numer_i` is less than a nonzero `denom_i`, `quot_o` is zero and `rem_o` equals `numer_i`.
- R7: When `denom_i` is 1, `quot_o` equals `numer_i` and `rem_o` is zero.
- R8: All outputs are combinational functions of the present inputs. They are valid in the same cycle the operands are applied, with no clock or state involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| numer_i | input | 32 | Dividend, unsigned |
| denom_i | input | 32 | Divisor, unsigned |
| quot_o | output | 32 | Quotient, goes to the low result register |
| rem_o | output | 32 | Remainder, goes to the high result register |
| zero_div_o | output | 1 | High when the divisor is zero |

## Verification
Every result of this block is due zero cycles after its operands change, because no register lies between the inputs and the outputs. The bench changes the operands just after a rising edge and reads the quotient, remainder and flag at the following falling edge. The long carry chains therefore have half a period of simulated time to settle before any comparison is made. No check waits for a later edge, and no operands are changed between the moment they are driven and the moment the outputs are sampled.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  parameter int unsigned DIV_WIDTH = 32;

  // Extends an unsigned divisor by one zero bit so it lines up with a signed partial remainder.
  function automatic logic [DIV_WIDTH:0] widen(input logic [DIV_WIDTH-1:0] val);
    return {1'b0, val};
  endfunction
endpackage

// File: rtl/nrdiv_row.sv
// One add/subtract row of the array. It is used for every row except the last.
module nrdiv_row #(
  parameter int unsigned W = nrdiv_pkg::DIV_WIDTH
) (
  input  logic [W:0]   prev_rem_i,
  input  logic         shift_in_i,
  input  logic [W-1:0] denom_i,
  output logic [W:0]   next_rem_o,
  output logic         qbit_o
);
  localparam int unsigned PW = W + 1;

  logic [PW-1:0] shifted;
  logic [PW-1:0] dext;

  always_comb begin
    shifted = {prev_rem_i[W-1:0], shift_in_i};
    dext    = {1'b0, denom_i};
    // A negative running remainder is corrected by adding the divisor. Otherwise the divisor is subtracted.
    if (prev_rem_i[W]) next_rem_o = shifted + dext;
    else               next_rem_o = shifted - dext;
    qbit_o = ~next_rem_o[W];
  end
endmodule

// File: rtl/nrdiv_last_row.sv
// The closing row. It works out the least significant quotient bit and then corrects the remainder once.
module nrdiv_last_row #(
  parameter int unsigned W = nrdiv_pkg::DIV_WIDTH
) (
  input  logic [W:0]   prev_rem_i,
  input  logic         shift_in_i,
  input  logic [W-1:0] denom_i,
  output logic [W-1:0] rem_o,
  output logic         qbit_o
);
  localparam int unsigned PW = W + 1;

  logic [PW-1:0] shifted;
  logic [PW-1:0] raw;

  always_comb begin
    shifted = {prev_rem_i[W-1:0], shift_in_i};
    if (prev_rem_i[W]) raw = shifted + nrdiv_pkg::widen(denom_i);
    else               raw = shifted - nrdiv_pkg::widen(denom_i);
    qbit_o = ~raw[W];
    // The true remainder lies in [0, divisor), so arithmetic modulo 2^W gives the exact value.
    if (raw[W]) rem_o = raw[W-1:0] + denom_i;
    else        rem_o = raw[W-1:0];
  end
endmodule

// File: rtl/nr_array_divider.sv
module nr_array_divider #(
  parameter int unsigned W = nrdiv_pkg::DIV_WIDTH
) (
  input  logic [W-1:0] numer_i,
  input  logic [W-1:0] denom_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         zero_div_o
);
  localparam int unsigned PW    = W + 1;
  localparam int unsigned NROWS = W - 1;

  logic [PW-1:0] part [0:NROWS];
  logic [W-1:0]  q_raw;
  logic [W-1:0]  r_raw;
  logic          dz;

  assign part[0] = '0;

  // Row k takes dividend bit W-1-k and produces quotient bit W-1-k.
  for (genvar k = 0; k < NROWS; k++) begin : g_row
    nrdiv_row #(.W(W)) u_row (
      .prev_rem_i (part[k]),
      .shift_in_i (numer_i[W-1-k]),
      .denom_i    (denom_i),
      .next_rem_o (part[k+1]),
      .qbit_o     (q_raw[W-1-k])
    );
  end

  nrdiv_last_row #(.W(W)) u_last (
    .prev_rem_i (part[NROWS]),
    .shift_in_i (numer_i[0]),
    .denom_i    (denom_i),
    .rem_o      (r_raw),
    .qbit_o     (q_raw[0])
  );

  always_comb begin
    dz         = (denom_i == '0);
    zero_div_o = dz;
    quot_o     = dz ? '0 : q_raw;
    rem_o      = dz ? '1 : r_raw;
  end
endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] numer_i,
  input logic [W-1:0] denom_i,
  input logic [W-1:0] quot_o,
  input logic [W-1:0] rem_o,
  input logic         zero_div_o
);
  logic [2*W-1:0] recon;

  always_comb begin
    recon = {{W{1'b0}}, quot_o} * {{W{1'b0}}, denom_i} + {{W{1'b0}}, rem_o};
    if (!zero_div_o) begin
      assert_identity_R2: assert (recon == {{W{1'b0}}, numer_i});
      assert_rem_below_divisor_R3: assert (rem_o < denom_i);
      assert_flag_low_nonzero_R5: assert (denom_i != '0);
    end
    if (zero_div_o) begin
      assert_fixed_result_R4: assert (quot_o == '0 && rem_o == '1);
    end
    if (denom_i != '0 && numer_i < denom_i) begin
      assert_small_dividend_R6: assert (quot_o == '0 && rem_o == numer_i);
    end
    if (denom_i == {{(W-1){1'b0}}, 1'b1}) begin
      assert_unit_divisor_R7: assert (quot_o == numer_i && rem_o == '0);
    end
  end
endmodule

bind nr_array_divider nrdiv_checker #(.W(W)) u_chk (
  .numer_i    (numer_i),
  .denom_i    (denom_i),
  .quot_o     (quot_o),
  .rem_o      (rem_o),
  .zero_div_o (zero_div_o)
);

// File: tb/sim_nr_array_divider.sv
module sim_nr_array_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND      = 3000;

  logic        clk;
  logic        rst_n;
  logic [31:0] numer;
  logic [31:0] denom;
  logic [31:0] quot;
  logic [31:0] rem;
  logic        zdiv;
  int          vectors;
  int          miscompares;
  bit          done;

  nr_array_divider u0 (
    .numer_i    (numer),
    .denom_i    (denom),
    .quot_o     (quot),
    .rem_o      (rem),
    .zero_div_o (zdiv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_q(input logic [31:0] a, input logic [31:0] b);
    return (b == 32'd0) ? 32'd0 : a / b;
  endfunction

  function automatic logic [31:0] ref_r(input logic [31:0] a, input logic [31:0] b);
    return (b == 32'd0) ? 32'hFFFF_FFFF : a % b;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: numer=%h denom=%h actual=%h expected=%h", tag, numer, denom, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    string tq;
    string tr;
    @(posedge clk);
    #1;
    numer = a;
    denom = b;
    @(negedge clk); // R8: sampled in the same cycle the operands were applied
    vectors++;
    if (b == 32'd0)      begin tq = "R4"; tr = "R4"; end
    else if (a < b)      begin tq = "R6"; tr = "R6"; end
    else if (b == 32'd1) begin tq = "R7"; tr = "R7"; end
    else                 begin tq = "R1"; tr = "R2"; end
    check(tq, quot, ref_q(a, b));
    check(tr, rem, ref_r(a, b));
    check("R5", {31'd0, zdiv}, {31'd0, (b == 32'd0)});
    if (b != 32'd0) check("R3", {31'd0, (rem < b)}, 32'd1);
  endtask

  initial begin
    done = 1'b0;
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    vectors = 0;
    miscompares = 0;
    rst_n = 1'b0;
    numer = 32'd0;
    denom = 32'd1;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Directed corner cases
    apply(32'd0, 32'd1);                  // R6 with a zero dividend
    apply(32'd5, 32'd7);                  // R6
    apply(32'd1, 32'hFFFF_FFFF);          // R6
    apply(32'd123456, 32'd1);             // R7
    apply(32'hFFFF_FFFF, 32'd1);          // R7
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R1 quotient one
    apply(32'hFFFF_FFFF, 32'd2);          // R1, R2
    apply(32'h8000_0000, 32'd3);          // R1, R2
    apply(32'd100, 32'd7);                // R1, R2
    apply(32'hFFFF_FFFE, 32'hFFFF_FFFF);  // R6 at the top of the range
    apply(32'd7, 32'd0);                  // R4, R5
    apply(32'd0, 32'd0);                  // R4, R5
    apply(32'hFFFF_FFFF, 32'd0);          // R4, R5
    // Constrained random stimulus
    for (int i = 0; i < NRAND; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom;
      case ($urandom % 5)
        0:       b = $urandom;
        1:       b = ($urandom & 32'hFF) + 32'd1;
        2:       b = 32'd1 << ($urandom % 32);
        3:       begin b = $urandom | 32'h8000_0000; a = a >> ($urandom % 32); end
        default: b = $urandom >> ($urandom % 32);
      endcase
      apply(a, b);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule